// File: doc/BRIEF.md
# Interrupt Status and Halt Controller

This block gathers event pulses from two I2C masters into one 32-bit status word and drives a single interrupt line. Each master has two command queues. The status bits are sticky: an event sets its bit and the bit stays set until software clears it. Only the bits enabled in a mask register reach the interrupt line. Clearing takes two steps. Software first writes ones into a staging register, and a commit write then removes the staged bits from the status word.

The same register port also carries two handshakes:

- **Halt.** A halt request stops a master and holds its halt output high. Once that master has been idle for a fixed number of cycles, its halt-acknowledge status bit is raised.
- **Reset.** A reset command is accepted only as one of three exact code values. It emits a one-cycle reset pulse to the selected masters. A fixed number of cycles later it raises the reset-done status bit.

Register writes are single-cycle strobes with a select code and a 32-bit data word. The event sources and the bus protocol in front of the write port sit outside this block.

Top module: `irq_halt_ctl`

## Requirements
- R1: After reset, status, mask, staged clear bits, irq, halt and rst_pulse are all zero.
- R2: An event pulse sets its status bit one clock later, at these positions:
  - read done: master 0 at bit 0 and master 1 at bit 12;
  - queue report, with ev_q_report index 2*master+queue: bits 4, 8, 16 and 20;
  - NACK, with ev_nack index 2*master+queue: bits 27, 28, 29 and 30;
  - fault lanes 0..7 of ev_fault: bits 1, 2, 5, 6, 7, 9, 10 and 11;
  - fault lanes 8..15 of ev_fault: the same positions plus 12.
- R3: A write with wr_sel=0 loads the mask. irq is high exactly when some status bit and the same mask bit are both 1.
- R4: A write with wr_sel=1 ORs wr_data into the staged clear bits and leaves status unchanged. A write with wr_sel=2 and wr_data[0]=1 clears the staged bits from status and empties the stage. A write with wr_sel=2 and wr_data[0]=0 does nothing.
- R5: An event that arrives in the same cycle as a commit which clears its bit leaves that bit set.
- R6: A write with wr_sel=3 raises halt[m] one clock later for each set wr_data[m], m=0..1. The halt-ack bit (25 for master 0, 26 for master 1) is set HALT_LAT clocks after the write edge while m_idle[m] stays high. The ack is given once per halt.
- R7: If m_idle[m] drops before the ack, the halt count for master m restarts from zero.
- R8: A write with wr_sel=4 pulses rst_pulse for one cycle for the masters that the data selects:
  - 0x0F73F3F7 selects both masters;
  - 0x000003F1 selects master 0;
  - 0x0003F001 selects master 1.
  Any other value is ignored.
- R9: Status bit 24 is set RST_LAT clocks after an accepted reset command, and the reset drops halt for each master it selects.
- R10: Status bits 3, 15 and 31 are never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rd_done | input | 2 | Read-done pulse per master |
| ev_q_report | input | 4 | Queue report pulse, index 2*master+queue |
| ev_nack | input | 4 | NACK pulse, index 2*master+queue |
| ev_fault | input | 16 | Other error pulses, 8 lanes per master |
| m_idle | input | 2 | Master queues stopped |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 mask, 1 stage clear, 2 commit, 3 halt, 4 reset |
| wr_data | input | 32 | Write data |
| irq | output | 1 | Interrupt line |
| status | output | 32 | Sticky status word |
| halt | output | 2 | Halt level per master |
| rst_pulse | output | 2 | One-cycle reset per master |

## Verification
The event-set path and the commit-clear path can both act on one status bit in the same cycle. The bench provokes this by driving a queue-report pulse and the commit write at the same clock edge, with that bit already staged for clearing. It judges the result from the status word seen after that edge, where the bit must still be set.

// File: rtl/irq_halt_ctl.sv
module irq_halt_ctl #(
  parameter int HALT_LAT = 4,
  parameter int RST_LAT  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ev_rd_done,
  input  logic [3:0]  ev_q_report,
  input  logic [3:0]  ev_nack,
  input  logic [15:0] ev_fault,
  input  logic [1:0]  m_idle,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic        irq,
  output logic [31:0] status,
  output logic [1:0]  halt,
  output logic [1:0]  rst_pulse
);
  localparam int HCW = $clog2(HALT_LAT + 1);
  localparam int RCW = $clog2(RST_LAT + 1);
  localparam logic [31:0] CMD_ALL = 32'h0F73F3F7;
  localparam logic [31:0] CMD_M0  = 32'h000003F1;
  localparam logic [31:0] CMD_M1  = 32'h0003F001;

  logic [31:0] status_q, mask_q, pend_q, ev_set;
  logic [1:0]  halt_q, hack, rst_sel;
  logic [HCW-1:0] hcnt [2];
  logic [RCW-1:0] rcnt;
  logic        rdone;

  wire wr_mask   = wr_en && wr_sel == 3'd0;
  wire wr_stage  = wr_en && wr_sel == 3'd1;
  wire wr_commit = wr_en && wr_sel == 3'd2 && wr_data[0];
  wire wr_halt   = wr_en && wr_sel == 3'd3;
  wire wr_rst    = wr_en && wr_sel == 3'd4;

  assign rst_sel[0] = wr_rst && (wr_data == CMD_ALL || wr_data == CMD_M0);
  assign rst_sel[1] = wr_rst && (wr_data == CMD_ALL || wr_data == CMD_M1);
  assign rdone = rcnt == RCW'(1);

  always_comb begin
    ev_set = '0;
    for (int m = 0; m < 2; m++) begin
      ev_set[12*m]     = ev_rd_done[m];
      ev_set[12*m + 4] = ev_q_report[2*m];
      ev_set[12*m + 8] = ev_q_report[2*m + 1];
      for (int k = 0; k < 8; k++)
        ev_set[12*m + k + ((k < 2) ? 1 : (k < 5) ? 3 : 4)] = ev_fault[8*m + k];
    end
    for (int i = 0; i < 4; i++) ev_set[27 + i] = ev_nack[i];
    ev_set[24] = rdone;
    ev_set[25] = hack[0];
    ev_set[26] = hack[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      mask_q    <= '0;
      pend_q    <= '0;
      rcnt      <= '0;
      rst_pulse <= '0;
    end else begin
      status_q  <= (status_q & ~(wr_commit ? pend_q : 32'h0)) | ev_set;
      if (wr_mask) mask_q <= wr_data;
      if (wr_commit) pend_q <= '0;
      else if (wr_stage) pend_q <= pend_q | wr_data;
      rst_pulse <= rst_sel;
      if (|rst_sel) rcnt <= RCW'(RST_LAT);
      else if (rcnt != '0) rcnt <= rcnt - RCW'(1);
    end
  end

  for (genvar m = 0; m < 2; m++) begin : g_halt
    assign hack[m] = halt_q[m] && m_idle[m] && !rst_sel[m] &&
                     hcnt[m] == HCW'(HALT_LAT - 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        halt_q[m] <= 1'b0;
        hcnt[m]   <= '0;
      end else begin
        if (rst_sel[m]) halt_q[m] <= 1'b0;
        else if (wr_halt && wr_data[m]) halt_q[m] <= 1'b1;
        if (rst_sel[m] || !halt_q[m]) hcnt[m] <= '0;
        else if (hcnt[m] != HCW'(HALT_LAT)) hcnt[m] <= m_idle[m] ? hcnt[m] + HCW'(1) : '0;
      end
    end
  end

  assign status = status_q;
  assign halt   = halt_q;
  assign irq    = |(status_q & mask_q);
endmodule

// File: rtl/irq_halt_ctl_chk.sv
module irq_halt_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  ev_rd_done,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic        irq,
  input logic [31:0] status,
  input logic [1:0]  halt,
  input logic [1:0]  rst_pulse
);
  AST_RD_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_done[0] |=> status[0]); // R2
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status != 32'h0); // R3
  AST_STAGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd1) |=> (($past(status) & ~status) == 32'h0)); // R4
  AST_ACK_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[25]) |-> halt[0]); // R6
  AST_RST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse[0] |=> (!rst_pulse[0] || $past(wr_en && wr_sel == 3'd4))); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !status[3] && !status[15] && !status[31]); // R10
endmodule

bind irq_halt_ctl irq_halt_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_rd_done(ev_rd_done), .wr_en(wr_en),
  .wr_sel(wr_sel), .irq(irq), .status(status), .halt(halt), .rst_pulse(rst_pulse)
);

// File: tb/irq_halt_ctl_tb.sv
`timescale 1ns/1ps
module irq_halt_ctl_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] ev_rd_done = 0, m_idle = 0;
  logic [3:0] ev_q_report = 0, ev_nack = 0;
  logic [15:0] ev_fault = 0;
  logic wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic irq;
  logic [31:0] status;
  logic [1:0] halt, rst_pulse;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_halt_ctl u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clear_all();
    wr(3'd1, 32'hFFFFFFFF);
    wr(3'd2, 32'h1);
  endtask

  function automatic int fault_pos(int lane);
    int p [8] = '{1, 2, 5, 6, 7, 9, 10, 11};
    return p[lane % 8] + 12 * (lane / 8);
  endfunction

  task automatic t_reset();
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
    chk("R1 halt", halt, 0);
    chk("R1 rst_pulse", rst_pulse, 0);
  endtask

  task automatic t_events();
    int qpos [4] = '{4, 8, 16, 20};
    for (int m = 0; m < 2; m++) begin
      @(negedge clk); ev_rd_done[m] = 1; @(negedge clk); ev_rd_done = 0;
      chk("R2 rd_done", status, 32'h1 << (12 * m));
      clear_all();
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ev_q_report[i] = 1; @(negedge clk); ev_q_report = 0;
      chk("R2 report", status, 32'h1 << qpos[i]);
      clear_all();
      @(negedge clk); ev_nack[i] = 1; @(negedge clk); ev_nack = 0;
      chk("R2 nack", status, 32'h1 << (27 + i));
      clear_all();
    end
    for (int l = 0; l < 16; l++) begin
      @(negedge clk); ev_fault[l] = 1; @(negedge clk); ev_fault = 0;
      chk("R2 fault", status, 32'h1 << fault_pos(l));
      clear_all();
    end
    chk("R4 cleared", status, 0);
  endtask

  task automatic t_all_events();
    logic [31:0] exp = 32'h1 | (32'h1 << 12) | (32'h1 << 4) | (32'h1 << 8) |
                       (32'h1 << 16) | (32'h1 << 20) | (32'hF << 27);
    for (int l = 0; l < 16; l++) exp |= 32'h1 << fault_pos(l);
    @(negedge clk); ev_rd_done = '1; ev_q_report = '1; ev_nack = '1; ev_fault = '1;
    @(negedge clk); ev_rd_done = 0; ev_q_report = 0; ev_nack = 0; ev_fault = 0;
    chk("R2 all events", status, exp);
    chk("R10 reserved bits", status & 32'h80008008, 0);
    clear_all();
  endtask

  task automatic t_irq();
    @(negedge clk); ev_rd_done[1] = 1; @(negedge clk); ev_rd_done = 0;
    chk("R3 unmasked irq", irq, 0);
    wr(3'd0, 32'h1000);
    chk("R3 masked irq", irq, 1);
    wr(3'd0, 32'h0001);
    chk("R3 other mask", irq, 0);
    wr(3'd0, 32'h0);
    clear_all();
  endtask

  task automatic t_staging();
    @(negedge clk); ev_rd_done[0] = 1; ev_q_report[0] = 1;
    @(negedge clk); ev_rd_done = 0; ev_q_report = 0;
    wr(3'd1, 32'h1);
    chk("R4 stage only", status, 32'h11);
    wr(3'd2, 32'h0);
    chk("R4 commit bit0 low", status, 32'h11);
    wr(3'd2, 32'h1);
    chk("R4 commit", status, 32'h10);
    @(negedge clk); ev_rd_done[0] = 1; @(negedge clk); ev_rd_done = 0;
    wr(3'd2, 32'h1);
    chk("R4 stage emptied", status, 32'h11);
    clear_all();
  endtask

  task automatic t_race();
    @(negedge clk); ev_q_report[1] = 1; @(negedge clk); ev_q_report = 0;
    wr(3'd1, 32'h100);
    @(negedge clk); wr_en = 1; wr_sel = 3'd2; wr_data = 32'h1; ev_q_report[1] = 1;
    @(negedge clk); wr_en = 0; ev_q_report = 0;
    chk("R5 event beats commit", status, 32'h100);
    clear_all();
    chk("R5 later clear", status, 0);
  endtask

  task automatic t_halt();
    m_idle = 2'b11;
    wr(3'd3, 32'h1);
    chk("R6 halt raised", halt, 2'b01);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R6 ack early", status[25], 0);
    end
    @(negedge clk); chk("R6 ack", status[25], 1);
    clear_all();
    repeat (6) @(negedge clk);
    chk("R6 single ack", status[25], 0);
  endtask

  task automatic t_halt_idle();
    m_idle[1] = 0;
    wr(3'd3, 32'h2);
    chk("R6 halt m1", halt, 2'b11);
    repeat (10) @(negedge clk);
    chk("R7 busy no ack", status[26], 0);
    m_idle[1] = 1;
    repeat (2) @(negedge clk);
    m_idle[1] = 0;
    @(negedge clk); m_idle[1] = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R7 restart", status[26], 0);
    end
    @(negedge clk); chk("R7 ack after restart", status[26], 1);
    clear_all();
  endtask

  task automatic t_reset_cmd();
    wr(3'd4, 32'h000003F1);
    chk("R8 m0 pulse", rst_pulse, 2'b01);
    chk("R9 m0 halt dropped", halt, 2'b10);
    @(negedge clk); chk("R8 pulse ends", rst_pulse, 0);
    chk("R9 done early", status[24], 0);
    @(negedge clk); chk("R9 done early2", status[24], 0);
    @(negedge clk); chk("R9 done", status[24], 1);
    clear_all();
    wr(3'd4, 32'h0003F003);
    chk("R8 bad code no pulse", rst_pulse, 0);
    chk("R8 bad code halt kept", halt, 2'b10);
    repeat (5) @(negedge clk);
    chk("R8 bad code no done", status[24], 0);
    wr(3'd4, 32'h0003F001);
    chk("R8 m1 pulse", rst_pulse, 2'b10);
    chk("R9 m1 halt dropped", halt, 2'b00);
    wr(3'd3, 32'h3);
    wr(3'd4, 32'h0F73F3F7);
    chk("R8 all pulse", rst_pulse, 2'b11);
    chk("R9 all halt dropped", halt, 2'b00);
    clear_all();
  endtask

  initial begin
    #1; t_reset();
    #10 rst_n = 1;
    t_reset();
    t_events();
    t_all_events();
    t_irq();
    t_staging();
    t_race();
    t_halt();
    t_halt_idle();
    t_reset_cmd();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule